// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Level Flags

This block is a first-in first-out queue that runs on one clock. Writers drive a write enable with a data word. Readers drive a read enable and take words from the data output. The storage is an inferred memory array. The width is set by a parameter, and so is the number of words.

Four registered level flags describe the fill state: full, empty, almost full and almost empty. The two "almost" thresholds are parameters. A write that the queue cannot accept, or a read that it cannot serve, produces a one-cycle error pulse. The error does not stick. The binary read and write pointers are brought out as counters.

Two build-time options change how the output behaves:
- A fall-through option presents the head word on the output with no read request.
- An optional output register adds one stage of latency. That stage has its own clock enable and its own synchronous load of a reset value.

Top module: `sync_flag_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both counters and both error pulses. It sets `empty` and `almostEmpty`, and clears `full`. It clears `almostFull` unless `AF_LEVEL` is at least `DEPTH`. Every output data stage loads `INIT_VAL`.
- R2: Without fall-through and without the output register, the words come out in write order. A read accepted at a clock edge places its word on `rdData` right after that edge. `rdData` then holds that word until the next accepted read.
- R3: `full` is high exactly when `DEPTH` words are stored. A write while `full` is high is discarded, and the write counter does not move. `wrErr` is high for the one cycle after that edge, and only then.
- R4: A read while `empty` is high is ignored: the read counter and the data output do not change. `rdErr` is high for the one cycle after that edge, and only then.
- R5: `almostEmpty` is high exactly when the number of stored words is at most `AE_LEVEL`.
- R6: `almostFull` is high exactly when the number of stored words is at least `DEPTH - AF_LEVEL`.
- R7: A read and a write in the same cycle, when the queue is neither empty nor full, leave the occupancy and all four level flags unchanged. Both counters still advance.
- R8: `wrCount` equals the number of accepted writes modulo `DEPTH`. `rdCount` equals the number of accepted reads modulo `DEPTH`.
- R9: With `FALL_THRU=1`, the oldest stored word is on the data stage from the edge after it was written, with no read request. After an accepted read, the next word replaces it. While the queue is empty, the stage shows `INIT_VAL`.
- R10: With `OUT_REG=1`, `rdData` is the data stage value delayed by one clock. It takes a new value only at edges where `outCe` is high, and otherwise holds.
- R11: With `OUT_REG=1`, `outRst` high at an edge loads `RESET_VAL` into `rdData`, whatever the value of `outCe`.
- R12: All four level flags are registered. They show the state produced by the operations at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| outCe | input | 1 | Clock enable of the output register |
| outRst | input | 1 | Synchronous load of RESET_VAL into the output register |
| rdData | output | DATA_W | Output word |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| almostFull | output | 1 | Occupancy at or above DEPTH - AF_LEVEL |
| almostEmpty | output | 1 | Occupancy at or below AE_LEVEL |
| wrErr | output | 1 | One-cycle pulse after a rejected write |
| rdErr | output | 1 | One-cycle pulse after a rejected read |
| wrCount | output | $clog2(DEPTH) | Binary write pointer |
| rdCount | output | $clog2(DEPTH) | Binary read pointer |

## Verification
The bench builds the queue with depth 8, 8-bit words, `AE_LEVEL=2` and `AF_LEVEL=3`. It builds all four combinations of `FALL_THRU` and `OUT_REG` side by side, and drives the same stimulus into each. The small depth lets fill, drain and mixed random phases cross both thresholds, overflow and underflow many times, and wrap both pointers repeatedly. Because the output register is built in two of the four copies, enable gating and reset-value loads are exercised against both the registered and the fall-through data stage.

// File: rtl/sflag_fifo_pkg.sv
package sflag_fifo_pkg;
  typedef struct packed {
    logic wrFire;   // write accepted this cycle
    logic rdFire;   // read accepted this cycle
  } fifoStrobe_t;
endpackage

// File: rtl/sflag_fifo_ctrl.sv
module sflag_fifo_ctrl
  import sflag_fifo_pkg::*;
#(
  parameter int          DEPTH    = 1024,
  parameter logic [12:0] AE_LEVEL = 13'h080,
  parameter logic [12:0] AF_LEVEL = 13'h080
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic                       rdEn,
  output fifoStrobe_t                strb,
  output logic [$clog2(DEPTH)-1:0]   wrPtr,
  output logic [$clog2(DEPTH)-1:0]   rdPtr,
  output logic                       full,
  output logic                       empty,
  output logic                       almostFull,
  output logic                       almostEmpty,
  output logic                       wrErr,
  output logic                       rdErr
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam int AF_AT  = DEPTH - int'(AF_LEVEL);
  localparam int AE_AT  = int'(AE_LEVEL);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] occNext;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    strb.wrFire = wrEn && !full;
    strb.rdFire = rdEn && !empty;
    occNext     = occ + CNT_W'(strb.wrFire) - CNT_W'(strb.rdFire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      occ         <= '0;
      full        <= 1'b0;
      empty       <= 1'b1;
      almostEmpty <= (0 <= AE_AT);
      almostFull  <= (0 >= AF_AT);
      wrErr       <= 1'b0;
      rdErr       <= 1'b0;
    end else begin
      if (strb.wrFire) wrPtr <= bump(wrPtr);
      if (strb.rdFire) rdPtr <= bump(rdPtr);
      occ         <= occNext;
      full        <= (int'(occNext) == DEPTH);
      empty       <= (occNext == '0);
      almostEmpty <= (int'(occNext) <= AE_AT);
      almostFull  <= (int'(occNext) >= AF_AT);
      wrErr       <= wrEn && full;
      rdErr       <= rdEn && empty;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);
  p_wr_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && full) |=> (wrErr && $stable(wrPtr)));
  p_rd_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (rdEn && empty) |=> (rdErr && $stable(rdPtr)));
  p_both_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && rdEn && !full && !empty) |=> $stable(occ));
  p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/sflag_fifo_data.sv
module sflag_fifo_data
  import sflag_fifo_pkg::*;
#(
  parameter int               DATA_W    = 36,
  parameter int               DEPTH     = 1024,
  parameter bit               FALL_THRU = 1'b0,
  parameter bit               OUT_REG   = 1'b1,
  parameter logic [DATA_W-1:0] INIT_VAL  = '0,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fifoStrobe_t              strb,
  input  logic [$clog2(DEPTH)-1:0] wrPtr,
  input  logic [$clog2(DEPTH)-1:0] rdPtr,
  input  logic                     isEmpty,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     outCe,
  input  logic                     outRst,
  output logic [DATA_W-1:0]        rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] stage0;

  always_ff @(posedge clk) begin
    if (strb.wrFire) mem[wrPtr] <= wrData;
  end

  generate
    if (FALL_THRU) begin : g_fall
      assign stage0 = isEmpty ? INIT_VAL : mem[rdPtr];
    end else begin : g_std
      logic [DATA_W-1:0] stageQ;
      always_ff @(posedge clk) begin
        if (rst)                          stageQ <= INIT_VAL;
        else if (strb.rdFire && !isEmpty) stageQ <= mem[rdPtr];
      end
      assign stage0 = stageQ;
    end

    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] outQ;
      always_ff @(posedge clk) begin
        if (rst)         outQ <= INIT_VAL;
        else if (outRst) outQ <= RESET_VAL;
        else if (outCe)  outQ <= stage0;
      end
      assign rdData = outQ;

      p_outrst_load_r11: assert property (@(posedge clk) disable iff (rst)
        outRst |=> (rdData == RESET_VAL));
      p_outce_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!outCe && !outRst) |=> $stable(rdData));
      p_outce_follow_r10: assert property (@(posedge clk) disable iff (rst)
        (outCe && !outRst) |=> (rdData == $past(stage0)));
    end else begin : g_direct
      assign rdData = stage0;
    end
  endgenerate
endmodule

// File: rtl/sync_flag_fifo.sv
module sync_flag_fifo
  import sflag_fifo_pkg::*;
#(
  parameter int                DATA_W    = 36,
  parameter int                DEPTH     = 1024,
  parameter logic [12:0]       AE_LEVEL  = 13'h080,
  parameter logic [12:0]       AF_LEVEL  = 13'h080,
  parameter bit                FALL_THRU = 1'b0,
  parameter bit                OUT_REG   = 1'b1,
  parameter logic [DATA_W-1:0] INIT_VAL  = '0,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rdEn,
  input  logic                     outCe,
  input  logic                     outRst,
  output logic [DATA_W-1:0]        rdData,
  output logic                     full,
  output logic                     empty,
  output logic                     almostFull,
  output logic                     almostEmpty,
  output logic                     wrErr,
  output logic                     rdErr,
  output logic [$clog2(DEPTH)-1:0] wrCount,
  output logic [$clog2(DEPTH)-1:0] rdCount
);
  fifoStrobe_t strb;

  sflag_fifo_ctrl #(
    .DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .strb(strb),
    .wrPtr(wrCount), .rdPtr(rdCount), .full(full), .empty(empty),
    .almostFull(almostFull), .almostEmpty(almostEmpty),
    .wrErr(wrErr), .rdErr(rdErr)
  );

  sflag_fifo_data #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FALL_THRU(FALL_THRU), .OUT_REG(OUT_REG),
    .INIT_VAL(INIT_VAL), .RESET_VAL(RESET_VAL)
  ) u_data (
    .clk(clk), .rst(rst), .strb(strb), .wrPtr(wrCount), .rdPtr(rdCount),
    .isEmpty(empty), .wrData(wrData), .outCe(outCe), .outRst(outRst),
    .rdData(rdData)
  );
endmodule

// File: tb/tb_sync_flag_fifo.sv
`timescale 1ns/1ps
module tb_sync_flag_fifo;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int AW = 3;
  localparam logic [12:0] AE = 13'd2;
  localparam logic [12:0] AF = 13'd3;
  localparam logic [DW-1:0] INITV = 8'hA5;
  localparam logic [DW-1:0] RESV  = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, outCe = 1'b0, outRst = 1'b0;
  logic [DW-1:0] wrData = '0;

  logic [DW-1:0] rdDataV [4];
  logic fullV [4], emptyV [4], afV [4], aeV [4], wErrV [4], rErrV [4];
  logic [AW-1:0] wcV [4], rcV [4];

  always #2.5 clk = ~clk;

  // index g: bit1 = fall-through, bit0 = output register
  for (genvar g = 0; g < 4; g++) begin : g_cfg
    sync_flag_fifo #(
      .DATA_W(DW), .DEPTH(DP), .AE_LEVEL(AE), .AF_LEVEL(AF),
      .FALL_THRU(bit'(g / 2)), .OUT_REG(bit'(g % 2)),
      .INIT_VAL(INITV), .RESET_VAL(RESV)
    ) dut (
      .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
      .outCe(outCe), .outRst(outRst), .rdData(rdDataV[g]),
      .full(fullV[g]), .empty(emptyV[g]), .almostFull(afV[g]),
      .almostEmpty(aeV[g]), .wrErr(wErrV[g]), .rdErr(rErrV[g]),
      .wrCount(wcV[g]), .rdCount(rcV[g])
    );
  end

  int nChk = 0;
  int nBad = 0;

  // reference model
  logic [DW-1:0] q [$];
  logic [DW-1:0] stdExp, ftExp, regStdExp, regFtExp;
  int wrCnt, rdCnt;
  logic wErrExp, rErrExp;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    q.delete();
    stdExp = INITV; ftExp = INITV; regStdExp = INITV; regFtExp = INITV;
    wrCnt = 0; rdCnt = 0; wErrExp = 1'b0; rErrExp = 1'b0;
  endtask

  task automatic checkAll(input bit orstNow);
    int occ;
    logic [DW-1:0] dexp [4];
    occ = q.size();
    dexp[0] = stdExp; dexp[1] = regStdExp; dexp[2] = ftExp; dexp[3] = regFtExp;
    for (int g = 0; g < 4; g++) begin
      chk("R3 full", int'(fullV[g]), int'(occ == DP));
      chk("R12 empty", int'(emptyV[g]), int'(occ == 0));
      chk("R5 almostEmpty", int'(aeV[g]), int'(occ <= int'(AE)));
      chk("R6 almostFull", int'(afV[g]), int'(occ >= DP - int'(AF)));
      chk("R3 wrErr", int'(wErrV[g]), int'(wErrExp));
      chk("R4 rdErr", int'(rErrV[g]), int'(rErrExp));
      chk("R8 wrCount", int'(wcV[g]), wrCnt);
      chk("R8 rdCount", int'(rcV[g]), rdCnt);
      case (g)
        0: chk("R2 data", int'(rdDataV[g]), int'(dexp[g]));
        2: chk("R9 fall-through data", int'(rdDataV[g]), int'(dexp[g]));
        default: chk(orstNow ? "R11 reset value" : "R10 registered data",
                     int'(rdDataV[g]), int'(dexp[g]));
      endcase
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [DW-1:0] wd,
                      input bit ce, input bit orst);
    logic [DW-1:0] preStd, preFt;
    bit wrOk, rdOk, both;
    logic [3:0] preFlags;
    int preOcc;
    preOcc = q.size();
    preFlags = {fullV[0], emptyV[0], aeV[0], afV[0]};
    wrEn = we; rdEn = re; wrData = wd; outCe = ce; outRst = orst;
    @(posedge clk);
    #1;
    preStd = stdExp; preFt = ftExp;
    wrOk = we && (preOcc < DP);
    rdOk = re && (preOcc > 0);
    both = we && re && (preOcc > 0) && (preOcc < DP);
    wErrExp = we && !wrOk;
    rErrExp = re && !rdOk;
    if (rdOk) begin
      stdExp = q.pop_front();
      rdCnt = (rdCnt + 1) % DP;
    end
    if (wrOk) begin
      q.push_back(wd);
      wrCnt = (wrCnt + 1) % DP;
    end
    ftExp = (q.size() == 0) ? INITV : q[0];
    if (orst) begin
      regStdExp = RESV; regFtExp = RESV;
    end else if (ce) begin
      regStdExp = preStd; regFtExp = preFt;
    end
    wrEn = 1'b0; rdEn = 1'b0; outRst = 1'b0;
    checkAll(orst);
    if (both)
      chk("R7 flags steady", int'({fullV[0], emptyV[0], aeV[0], afV[0]}), int'(preFlags));
  endtask

  task automatic doReset();
    wrEn = 1'b0; rdEn = 1'b0; outRst = 1'b0; outCe = 1'b0;
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    modelReset();
    for (int g = 0; g < 4; g++) begin
      chk("R1 empty", int'(emptyV[g]), 1);
      chk("R1 full", int'(fullV[g]), 0);
      chk("R1 almostEmpty", int'(aeV[g]), 1);
      chk("R1 almostFull", int'(afV[g]), 0);
      chk("R1 counts", int'({wcV[g], rcV[g]}), 0);
      chk("R1 errors", int'({wErrV[g], rErrV[g]}), 0);
      chk("R1 init data", int'(rdDataV[g]), int'(INITV));
    end
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    #1;
    doReset();
    // fill past full: R3 overflow
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, DW'(8'h10 + i), 1'b1, 1'b0);
    // drain past empty: R4 underflow
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '0, 1'b1, 1'b0);
    // R10 enable gating and R11 reset value with enable high
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, DW'(8'h60 + i), 1'b1, 1'b0);
    step(1'b0, 1'b1, '0, 1'b0, 1'b0);
    step(1'b0, 1'b1, '0, 1'b0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b1, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 8'h77, 1'b1, 1'b0);
    step(1'b1, 1'b1, 8'h78, 1'b1, 1'b0);
    // random sweeps: write-heavy, read-heavy, balanced
    lfsr = 8'h5B;
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 200; i++) begin
        bit we, re;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ph)
          0: begin we = (lfsr[1:0] != 2'b00); re = (lfsr[3:2] == 2'b00); end
          1: begin we = (lfsr[1:0] == 2'b00); re = (lfsr[3:2] != 2'b00); end
          default: begin we = lfsr[0]; re = lfsr[2]; end
        endcase
        step(we, re, lfsr ^ 8'hC3, lfsr[5] | lfsr[6], lfsr[7:3] == 5'd0);
      end
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, DW'(8'h90 + i), 1'b1, 1'b0);
    end
    // reset with data stored: R1
    doReset();
    step(1'b1, 1'b0, 8'hE1, 1'b1, 1'b0);
    step(1'b0, 1'b1, '0, 1'b1, 1'b0);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule